// File: doc/BRIEF.md
# Bidirectional Ramp Address Sequencer

This block produces read addresses for a 1024-word waveform memory in a two-segment ramp mode. Two segment descriptors come in as static inputs. Each descriptor holds a lower address, an upper address and a step interval. An external direction input steers the walk. When it is high, the sequencer climbs through the up segment, from that segment's lower address towards its upper address. When it is low, it descends through the down segment, from that segment's upper address towards its lower address. A programmable down-counter sets the pace of each step.

The mode does nothing until it is armed. Arming comes from an update strobe or from any change of the profile-select input. After arming, every edge of the synchronized direction input does three things at once: it drops the current position, loads the boundary of the newly selected segment, and restarts the pacing timer. When the walk reaches the far boundary of a segment, the address freezes and a halted flag is raised. The flag clears on the next direction change. A one-clock valid strobe marks every load and every step, so a downstream memory read can be qualified directly.

Top module: `ramp_addr_seq`

## Requirements
- R1: Until the block is armed, `addr_o` stays 0, `addr_vld_o` stays 0 and `halted_o` stays 0, whatever the direction input does. Arming happens on a one-clock pulse of `upd_strobe` or on any change of `prof_sel`.
- R2: After arming, a 0-to-1 change of `dir_in` loads `up_lo` into `addr_o` and pulses `addr_vld_o`. Both are visible after the third rising clock edge that follows the change (two synchronizer stages plus one load register).
- R3: While walking up, the address rises by exactly 1 per step. With an up step interval of S, consecutive steps are S+1 clocks apart, and the first step comes S+1 clocks after the load.
- R4: When the upward walk reaches `up_hi`, `halted_o` goes to 1. The address then stays put and no valid pulse occurs for as long as `dir_in` stays 1.
- R5: After arming, a 1-to-0 change of `dir_in` loads `dn_hi` and then falls by exactly 1 per step. With a down step interval of S, steps are S+1 clocks apart.
- R6: When the downward walk reaches `dn_lo`, `halted_o` goes to 1 and the address stays put while `dir_in` stays 0.
- R7: A direction change in the middle of a ramp drops the current position at once. The new segment's boundary is loaded, and the next step comes a full S+1 clocks after that load, where S is the new segment's step interval.
- R8: `halted_o` clears on the load caused by a direction change. If the loaded boundary already equals the segment's far boundary (lower address equal to upper address), `halted_o` is 1 straight after that load.
- R9: `addr_vld_o` is a one-clock pulse that occurs on every load and every step, and at no other time. `addr_o` never changes without it.
- R10: A change of `prof_sel` on its own, with no strobe, arms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_strobe | input | 1 | One-clock arming pulse |
| prof_sel | input | 3 | Profile select; any change arms the block |
| dir_in | input | 1 | Asynchronous ramp direction (1 = up segment) |
| up_lo | input | 10 | Up segment lower address (load point) |
| up_hi | input | 10 | Up segment upper address (halt point) |
| up_step | input | 16 | Up segment step interval |
| dn_lo | input | 10 | Down segment lower address (halt point) |
| dn_hi | input | 10 | Down segment upper address (load point) |
| dn_step | input | 16 | Down segment step interval |
| addr_o | output | 10 | Current memory address |
| addr_vld_o | output | 1 | One-clock pulse on each load or step |
| halted_o | output | 1 | Walk stopped at a segment boundary |

## Verification
The bound checker watches several invariants on every cycle:
- the address is quiet and the strobe is absent before arming;
- the address never moves without the valid strobe;
- every step moves the address by exactly one in the active direction;
- a rising-edge load lands on the up segment's lower address;
- no step happens while halted.

Other properties involve cycle counts and whole sequences, so only the bench scenarios can show them:
- the three-clock latency from the direction change;
- the S+1 step spacing;
- the timer restart after a reversal in mid-ramp;
- arming by a profile change;
- the segment whose lower and upper addresses are equal and which halts at once.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } ramp_dir_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/rsq_dir_sync.sv
module rsq_dir_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[LAST-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign level = sh_q[LAST-1];
  assign rise  =  sh_q[LAST-1] & ~sh_q[LAST];
  assign fall  = ~sh_q[LAST-1] &  sh_q[LAST];
endmodule

// File: rtl/rsq_arm_ctrl.sv
module rsq_arm_ctrl #(
  parameter int unsigned PROF_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_strobe,
  input  logic [PROF_W-1:0] prof_sel,
  output logic              armed
);
  logic [PROF_W-1:0] prof_q;
  logic              armed_q, armed_d;
  logic              prof_chg;

  always_comb begin
    prof_chg = (prof_sel != prof_q);
    armed_d  = armed_q | upd_strobe | prof_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prof_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prof_q  <= prof_sel;
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;
endmodule

// File: rtl/rsq_step_timer.sv
module rsq_step_timer #(
  parameter int unsigned STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  logic [STEP_W-1:0] reload,
  output logic              tick
);
  logic [STEP_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    tick   = run & (cnt_q == '0);
    cnt_en = restart | run;
    cnt_d  = cnt_q;
    if (restart)      cnt_d = reload;
    else if (tick)    cnt_d = reload;
    else if (run)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rsq_addr_ctr.sv
module rsq_addr_ctr #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic              up,
  input  logic [ADDR_W-1:0] bound,
  output logic [ADDR_W-1:0] addr,
  output logic              halted,
  output logic              vld
);
  logic [ADDR_W-1:0] addr_q, addr_d, addr_nxt;
  logic              halt_q, halt_d;
  logic              vld_d, vld_q;
  logic              upd_en;

  always_comb begin
    addr_nxt = up ? (addr_q + 1'b1) : (addr_q - 1'b1);
    upd_en   = load | step;
    addr_d   = addr_q;
    halt_d   = halt_q;
    vld_d    = 1'b0;
    if (load) begin
      addr_d = load_val;
      halt_d = (load_val == bound);
      vld_d  = 1'b1;
    end else if (step) begin
      addr_d = addr_nxt;
      halt_d = (addr_nxt == bound);
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      halt_q <= 1'b0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      halt_q <= halt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign addr   = addr_q;
  assign halted = halt_q;
  assign vld    = vld_q;
endmodule

// File: rtl/ramp_addr_seq.sv
module ramp_addr_seq
  import ramp_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned STEP_W = 16,
  parameter int unsigned PROF_W = 3,
  parameter int unsigned SYNC_N = SYNC_STAGES_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_strobe,
  input  logic [PROF_W-1:0] prof_sel,
  input  logic              dir_in,
  input  logic [ADDR_W-1:0] up_lo,
  input  logic [ADDR_W-1:0] up_hi,
  input  logic [STEP_W-1:0] up_step,
  input  logic [ADDR_W-1:0] dn_lo,
  input  logic [ADDR_W-1:0] dn_hi,
  input  logic [STEP_W-1:0] dn_step,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_vld_o,
  output logic              halted_o
);
  logic      dir_lvl, dir_rise, dir_fall;
  logic      armed;
  logic      load_go, step_go, tick;
  logic      run_q, run_d;
  ramp_dir_e seg_dir_q, seg_dir_d;
  logic      seg_up;
  logic [ADDR_W-1:0] load_val, bound;
  logic [STEP_W-1:0] step_reload;
  logic      timer_run;

  rsq_dir_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(dir_in),
    .level(dir_lvl), .rise(dir_rise), .fall(dir_fall)
  );

  rsq_arm_ctrl #(.PROF_W(PROF_W)) u_arm (
    .clk(clk), .rst_n(rst_n), .upd_strobe(upd_strobe),
    .prof_sel(prof_sel), .armed(armed)
  );

  always_comb begin
    load_go   = armed & (dir_rise | dir_fall);
    run_d     = run_q | load_go;
    seg_dir_d = load_go ? (dir_lvl ? DIR_UP : DIR_DOWN) : seg_dir_q;
    seg_up    = (seg_dir_q == DIR_UP);
    load_val  = dir_lvl ? up_lo : dn_hi;
    if (load_go) bound = dir_lvl ? up_hi : dn_lo;
    else         bound = seg_up ? up_hi : dn_lo;
    step_reload = load_go ? (dir_lvl ? up_step : dn_step)
                          : (seg_up ? up_step : dn_step);
    timer_run = run_q & ~halted_o & ~load_go;
    step_go   = tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      seg_dir_q <= DIR_DOWN;
    end else begin
      run_q     <= run_d;
      seg_dir_q <= seg_dir_d;
    end
  end

  rsq_step_timer #(.STEP_W(STEP_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(load_go), .run(timer_run),
    .reload(step_reload), .tick(tick)
  );

  rsq_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load_go), .load_val(load_val),
    .step(step_go), .up(seg_up), .bound(bound),
    .addr(addr_o), .halted(halted_o), .vld(addr_vld_o)
  );
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              armed,
  input logic              load_go,
  input logic              step_go,
  input logic              seg_up,
  input logic              dir_lvl,
  input logic [ADDR_W-1:0] up_lo,
  input logic [ADDR_W-1:0] addr_o,
  input logic              addr_vld_o,
  input logic              halted_o
);
  AST_IDLE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!addr_vld_o && addr_o == '0 && !halted_o)); // R1

  AST_RISE_LOADS_UP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && dir_lvl) |=> (addr_o == $past(up_lo))); // R2

  AST_UP_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && seg_up) |=> (addr_o == $past(addr_o) + 1'b1)); // R3

  AST_DN_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && !seg_up) |=> (addr_o == $past(addr_o) - 1'b1)); // R5

  AST_HALT_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> !step_go); // R4

  AST_ADDR_MOVE_HAS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_o) |-> addr_vld_o); // R9
endmodule

bind ramp_addr_seq rsq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .load_go(load_go),
  .step_go(step_go), .seg_up(seg_up), .dir_lvl(dir_lvl), .up_lo(up_lo),
  .addr_o(addr_o), .addr_vld_o(addr_vld_o), .halted_o(halted_o)
);

// File: tb/ramp_addr_seq_test.sv
`timescale 1ns/1ps
module ramp_addr_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_strobe = 1'b0;
  logic [2:0] prof_sel = 3'd0;
  logic dir_in = 1'b0;
  logic [9:0] up_lo = 10'd100, up_hi = 10'd103, dn_lo = 10'd50, dn_hi = 10'd53;
  logic [15:0] up_step = 16'd2, dn_step = 16'd1;
  logic [9:0] addr_o;
  logic addr_vld_o, halted_o;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ramp_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .upd_strobe(upd_strobe), .prof_sel(prof_sel),
    .dir_in(dir_in), .up_lo(up_lo), .up_hi(up_hi), .up_step(up_step),
    .dn_lo(dn_lo), .dn_hi(dn_hi), .dn_step(dn_step),
    .addr_o(addr_o), .addr_vld_o(addr_vld_o), .halted_o(halted_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Change direction, then expect the load three edges later.
  task automatic flip_dir(input bit v, input int exp_addr, input string tag);
    @(negedge clk);
    dir_in = v;
    repeat (2) @(negedge clk);
    chk(addr_vld_o == 1'b0, {tag, " no early vld"}, addr_vld_o, 0);
    @(negedge clk);
    chk(addr_vld_o == 1'b1, {tag, " load vld"}, addr_vld_o, 1);
    chk(addr_o == exp_addr[9:0], {tag, " load addr"}, addr_o, exp_addr);
  endtask

  // Expect the next vld after exactly gap clocks, carrying exp_addr.
  task automatic next_step(input int gap, input int exp_addr, input string tag);
    int seen = 0;
    for (int i = 1; i <= gap; i++) begin
      @(negedge clk);
      if (addr_vld_o && seen == 0) seen = i;
    end
    chk(seen == gap, {tag, " step spacing"}, seen, gap);
    chk(addr_o == exp_addr[9:0], {tag, " step addr"}, addr_o, exp_addr);
  endtask

  task automatic quiet(input int cyc, input int exp_addr, input string tag);
    int pulses = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (addr_vld_o) pulses++;
    end
    chk(pulses == 0, {tag, " no vld"}, pulses, 0);
    chk(addr_o == exp_addr[9:0], {tag, " addr held"}, addr_o, exp_addr);
  endtask

  task automatic t_reset();
    do_reset();
    chk(addr_o == 10'd0 && !addr_vld_o && !halted_o, "R1 reset state", addr_o, 0);
  endtask

  task automatic t_unarmed();
    @(negedge clk); dir_in = 1'b1;
    quiet(10, 0, "R1 unarmed rise");
    @(negedge clk); dir_in = 1'b0;
    quiet(10, 0, "R1 unarmed fall");
    chk(!halted_o, "R1 unarmed halted", halted_o, 0);
  endtask

  task automatic t_up_ramp();
    @(negedge clk); upd_strobe = 1'b1;
    @(negedge clk); upd_strobe = 1'b0;
    flip_dir(1'b1, 100, "R2");
    chk(!halted_o, "R8 not halted after load", halted_o, 0);
    next_step(3, 101, "R3 first");
    next_step(3, 102, "R3 second");
    next_step(3, 103, "R3 third");
    chk(halted_o, "R4 halted at up_hi", halted_o, 1);
    quiet(20, 103, "R4 held");
    chk(halted_o, "R4 still halted", halted_o, 1);
  endtask

  task automatic t_down_ramp();
    flip_dir(1'b0, 53, "R5");
    chk(!halted_o, "R8 halted cleared", halted_o, 0);
    next_step(2, 52, "R5 a");
    next_step(2, 51, "R5 b");
    next_step(2, 50, "R6 last");
    chk(halted_o, "R6 halted at dn_lo", halted_o, 1);
    quiet(15, 50, "R6 held");
  endtask

  task automatic t_reverse();
    flip_dir(1'b1, 100, "R7 up reload");
    next_step(3, 101, "R7 up step");
    @(negedge clk);
    flip_dir(1'b0, 53, "R7 mid reversal");
    next_step(2, 52, "R7 restarted timer");
  endtask

  task automatic t_prof_and_flat();
    dir_in = 1'b0;
    do_reset();
    up_lo = 10'd200; up_hi = 10'd200; dn_step = 16'd0;
    @(negedge clk); dir_in = 1'b1;
    quiet(6, 0, "R10 still unarmed");
    @(negedge clk); dir_in = 1'b0;
    quiet(6, 0, "R10 unarmed fall");
    @(negedge clk); prof_sel = 3'd5;
    @(negedge clk);
    flip_dir(1'b1, 200, "R10 profile arm");
    chk(halted_o, "R8 flat segment halts at once", halted_o, 1);
    quiet(8, 200, "R8 flat held");
    flip_dir(1'b0, 53, "R9 down load");
    next_step(1, 52, "R9 zero interval");
    @(negedge clk);
    chk(addr_vld_o && addr_o == 10'd51, "R9 back-to-back", addr_o, 51);
  endtask

  initial begin
    t_reset();
    t_unarmed();
    t_up_ramp();
    t_down_ramp();
    t_reverse();
    t_prof_and_flat();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule